// File: doc/BRIEF.md
# Effective Address Indirection Sequencer

This block turns a 36-bit instruction word into a 30-bit effective address and then starts the operand access that a 3-bit access class asks for. The address may be formed from a displacement alone, or with an index register added to it. It may also be formed by indirection: the sequencer reads a pointer word from the address it has formed and evaluates that word in turn. The chain is followed until a word without indirection is reached.

A pending interrupt is honoured while a pointer read is outstanding, and the chain is then abandoned. A page fail at any step ends the sequence with a trap. An illegal pointer word ends it with a fault, and so does a chain longer than a set limit. Each started sequence ends with exactly one one-cycle pulse: done, trap, fault or interrupt-taken. The done pulse carries the final address, the operand and a prefetch flag.

Top module: `ea_chain_seq`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, done, trap, fault, int_taken, fetch_go and mem_req are all 0.
- R2: The instruction word is always read in local format: bit 22 is the indirect flag, bits 21:18 select an index register and bits 17:0 are a zero-extended displacement. A pointer word whose bits 35:34 are 10 is also local. A pointer word with 00 or 01 in bits 35:34 is global: bit 34 is the indirect flag, bits 33:30 select an index register and bits 29:0 are the base. The address is the base plus bits 29:0 of the selected index register, taken modulo 2^30. Index select 0 adds nothing.
- R3: When the indirect flag is set, the formed address is read with a pointer read (mem_kind 0), and the returned word is evaluated again. This repeats until a word with a clear indirect flag is reached.
- R4: A pointer word whose bits 35:34 are 11 ends the sequence with a one-cycle fault pulse and no done.
- R5: A chain that would need more than MAX_CHAIN pointer reads ends with a fault after exactly MAX_CHAIN pointer reads.
- R6: If irq_pending is high while a pointer read is outstanding, the chain is abandoned. int_taken pulses for one cycle and the request is withdrawn. irq_pending has no effect at any other time.
- R7: page_fail high in any busy cycle ends the sequence with a one-cycle trap pulse and no done.
- R8: Classes 0, 1 and 2 make no operand access. done arrives one cycle after address formation, with done_data equal to 0 for classes 0 and 1, and equal to the zero-extended address for class 2.
- R9: Classes 1 and 5 pulse fetch_go in the cycle of done, with fetch_addr = pc + 1 and done_pf = 1. For other classes done_pf is 0 and fetch_go stays low.
- R10: Class 3 issues a write-test request (mem_kind 1) at the address. On its acknowledge, done presents ac_data as the operand.
- R11: Classes 4 and 5 issue a read (mem_kind 0), class 6 a read with write check (mem_kind 2) and class 7 a read-pause-write read (mem_kind 3). done carries mem_rdata as the operand. A request holds its address and kind until it is acknowledged or aborted.
- R12: start is ignored while a sequence is in progress.
- R13: At most one of done, trap, fault and int_taken is high in any cycle, and mem_req is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a sequence (taken only when idle) |
| insn | input | 36 | Instruction word |
| acc_class | input | 3 | Operand access class |
| pc | input | 30 | Address of the current instruction |
| ac_data | input | 36 | Accumulator value for class 3 |
| idx_sel | output | 4 | Index register select |
| idx_data | input | 36 | Selected index register contents |
| mem_req | output | 1 | Memory request, held until acknowledge |
| mem_kind | output | 2 | 0 read, 1 write test, 2 read with write check, 3 read-pause-write |
| mem_addr | output | 30 | Request address |
| mem_ack | input | 1 | One-cycle acknowledge |
| mem_rdata | input | 36 | Read data, valid with mem_ack |
| page_fail | input | 1 | Page fail from paging |
| irq_pending | input | 1 | Interrupt pending |
| done | output | 1 | One-cycle completion pulse |
| done_addr | output | 30 | Final effective address |
| done_data | output | 36 | Operand or result |
| done_pf | output | 1 | A prefetch was started |
| fetch_go | output | 1 | Start prefetch pulse |
| fetch_addr | output | 30 | Prefetch address |
| trap | output | 1 | Page-fail trap pulse |
| fault | output | 1 | Illegal pointer or chain-limit pulse |
| int_taken | output | 1 | Chain abandoned for an interrupt |

## Verification
The assertions assume a memory that raises mem_ack for one cycle only while mem_req is high, with one acknowledge per request. They also assume that an abort caused by page_fail or irq_pending is reported only for a cause seen in the preceding cycle. The bench's responder follows this: it counts latency only while a request is open and not held, and it drops its acknowledge in the cycle after. Page fails and interrupts are raised by the bench only after a request has been outstanding for some cycles, and they are lowered once the sequence has ended.

// File: rtl/ea_chain_pkg.sv
package ea_chain_pkg;
  localparam int WORD_W    = 36;
  localparam int ADDR_W    = 30;
  localparam int IDX_W     = 4;
  localparam int LOC_W     = 18;
  localparam int L_IND_BIT = 22;
  localparam int L_IDX_LSB = 18;
  localparam int G_IND_BIT = 34;
  localparam int G_IDX_LSB = 30;
  localparam logic [1:0] FMT_LOCAL = 2'b10;
  localparam logic [1:0] FMT_BAD   = 2'b11;

  typedef enum logic [1:0] {
    K_READ = 2'd0, K_WTEST = 2'd1, K_READ_WCHK = 2'd2, K_RPW = 2'd3
  } mem_kind_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0, S_EVAL = 2'd1, S_PTR = 2'd2, S_OPND = 2'd3
  } state_e;

  typedef struct packed {
    logic              ind;
    logic [IDX_W-1:0]  idx;
    logic [ADDR_W-1:0] base;
  } ref_t;

  // Split a word into indirect flag, index select and base address.
  function automatic ref_t split_word(input logic [WORD_W-1:0] w, input logic is_insn);
    ref_t r;
    if (is_insn || w[WORD_W-1 -: 2] == FMT_LOCAL) begin
      r.ind  = w[L_IND_BIT];
      r.idx  = w[L_IDX_LSB +: IDX_W];
      r.base = ADDR_W'(w[LOC_W-1:0]);
    end else begin
      r.ind  = w[G_IND_BIT];
      r.idx  = w[G_IDX_LSB +: IDX_W];
      r.base = w[ADDR_W-1:0];
    end
    return r;
  endfunction

  function automatic logic [ADDR_W-1:0] ea_sum(input logic [ADDR_W-1:0] base,
                                               input logic [IDX_W-1:0] idx,
                                               input logic [ADDR_W-1:0] xr);
    return (idx == '0) ? base : base + xr;
  endfunction

  function automatic logic ptr_illegal(input logic [WORD_W-1:0] w);
    return w[WORD_W-1 -: 2] == FMT_BAD;
  endfunction
endpackage

// File: rtl/ea_form.sv
module ea_form
  import ea_chain_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic              is_insn,
  input  logic [WORD_W-1:0] idx_data,
  output logic [IDX_W-1:0]  idx_sel,
  output logic              want_ind,
  output logic [ADDR_W-1:0] ea
);
  ref_t r;
  logic unused_xr_hi;
  assign r            = split_word(word, is_insn);
  assign idx_sel      = r.idx;
  assign want_ind     = r.ind;
  assign ea           = ea_sum(r.base, r.idx, idx_data[ADDR_W-1:0]);
  assign unused_xr_hi = ^idx_data[WORD_W-1:ADDR_W];
endmodule

// File: rtl/ea_hop_limit.sv
module ea_hop_limit #(
  parameter int MAX_CHAIN = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic at_limit
);
  localparam int HOP_W = $clog2(MAX_CHAIN + 1);
  logic [HOP_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else if (inc) cnt_q <= cnt_q + HOP_W'(1);
  end

  assign at_limit = (cnt_q == HOP_W'(MAX_CHAIN));
endmodule

// File: rtl/ea_class_map.sv
module ea_class_map
  import ea_chain_pkg::*;
(
  input  logic [2:0] cls,
  output logic       needs_mem,
  output logic       prefetch,
  output logic       use_ac,
  output logic       addr_as_data,
  output logic [1:0] kind
);
  always_comb begin
    needs_mem    = cls >= 3'd3;
    prefetch     = (cls == 3'd1) || (cls == 3'd5);
    use_ac       = cls == 3'd3;
    addr_as_data = cls == 3'd2;
    case (cls)
      3'd3:    kind = K_WTEST;
      3'd6:    kind = K_READ_WCHK;
      3'd7:    kind = K_RPW;
      default: kind = K_READ;
    endcase
  end
endmodule

// File: rtl/ea_chain_seq.sv
module ea_chain_seq
  import ea_chain_pkg::*;
#(
  parameter int MAX_CHAIN = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] insn,
  input  logic [2:0]        acc_class,
  input  logic [ADDR_W-1:0] pc,
  input  logic [WORD_W-1:0] ac_data,
  output logic [IDX_W-1:0]  idx_sel,
  input  logic [WORD_W-1:0] idx_data,
  output logic              mem_req,
  output logic [1:0]        mem_kind,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              page_fail,
  input  logic              irq_pending,
  output logic              done,
  output logic [ADDR_W-1:0] done_addr,
  output logic [WORD_W-1:0] done_data,
  output logic              done_pf,
  output logic              fetch_go,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic              trap,
  output logic              fault,
  output logic              int_taken
);
  localparam int PAD_W = WORD_W - ADDR_W;

  state_e            state_q;
  logic [WORD_W-1:0] word_q;
  logic              first_q;
  logic [ADDR_W-1:0] addr_q, pc_q;
  logic [2:0]        cls_q;
  logic              done_q, trap_q, fault_q, int_q, fetch_q, dpf_q;
  logic [ADDR_W-1:0] daddr_q;
  logic [WORD_W-1:0] ddata_q;

  logic              want_ind, at_limit;
  logic [ADDR_W-1:0] ea_now;
  logic              cls_mem, cls_pf, cls_ac, cls_addr;
  logic [1:0]        cls_kind;

  // Named internal events
  logic ev_start, ev_abort_pf, ev_irq_take, ev_ptr_arrive, ev_ptr_bad, ev_hop;
  assign ev_start      = (state_q == S_IDLE) && start;
  assign ev_abort_pf   = (state_q != S_IDLE) && page_fail;
  assign ev_irq_take   = (state_q == S_PTR) && !page_fail && irq_pending;
  assign ev_ptr_arrive = (state_q == S_PTR) && !page_fail && !irq_pending && mem_ack;
  assign ev_ptr_bad    = ev_ptr_arrive && ptr_illegal(mem_rdata);
  assign ev_hop        = (state_q == S_EVAL) && !page_fail && want_ind && !at_limit;

  ea_form u_form (
    .word(word_q), .is_insn(first_q), .idx_data(idx_data),
    .idx_sel(idx_sel), .want_ind(want_ind), .ea(ea_now)
  );

  ea_hop_limit #(.MAX_CHAIN(MAX_CHAIN)) u_hops (
    .clk(clk), .rst_n(rst_n), .clr(ev_start), .inc(ev_hop), .at_limit(at_limit)
  );

  ea_class_map u_map (
    .cls(cls_q), .needs_mem(cls_mem), .prefetch(cls_pf), .use_ac(cls_ac),
    .addr_as_data(cls_addr), .kind(cls_kind)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      word_q  <= '0;
      first_q <= 1'b0;
      addr_q  <= '0;
      pc_q    <= '0;
      cls_q   <= '0;
      done_q  <= 1'b0;
      trap_q  <= 1'b0;
      fault_q <= 1'b0;
      int_q   <= 1'b0;
      fetch_q <= 1'b0;
      dpf_q   <= 1'b0;
      daddr_q <= '0;
      ddata_q <= '0;
    end else begin
      done_q  <= 1'b0;
      trap_q  <= 1'b0;
      fault_q <= 1'b0;
      int_q   <= 1'b0;
      fetch_q <= 1'b0;
      if (ev_abort_pf) begin
        trap_q  <= 1'b1;
        state_q <= S_IDLE;
      end else begin
        case (state_q)
          S_IDLE: if (start) begin
            word_q  <= insn;
            first_q <= 1'b1;
            cls_q   <= acc_class;
            pc_q    <= pc;
            state_q <= S_EVAL;
          end
          S_EVAL: begin
            if (want_ind) begin
              if (at_limit) begin
                fault_q <= 1'b1;
                state_q <= S_IDLE;
              end else begin
                addr_q  <= ea_now;
                state_q <= S_PTR;
              end
            end else if (!cls_mem) begin
              done_q  <= 1'b1;
              daddr_q <= ea_now;
              ddata_q <= cls_addr ? {{PAD_W{1'b0}}, ea_now} : '0;
              dpf_q   <= cls_pf;
              fetch_q <= cls_pf;
              state_q <= S_IDLE;
            end else begin
              addr_q  <= ea_now;
              state_q <= S_OPND;
            end
          end
          S_PTR: begin
            if (ev_irq_take) begin
              int_q   <= 1'b1;
              state_q <= S_IDLE;
            end else if (ev_ptr_bad) begin
              fault_q <= 1'b1;
              state_q <= S_IDLE;
            end else if (ev_ptr_arrive) begin
              word_q  <= mem_rdata;
              first_q <= 1'b0;
              state_q <= S_EVAL;
            end
          end
          S_OPND: if (mem_ack) begin
            done_q  <= 1'b1;
            daddr_q <= addr_q;
            ddata_q <= cls_ac ? ac_data : mem_rdata;
            dpf_q   <= cls_pf;
            fetch_q <= cls_pf;
            state_q <= S_IDLE;
          end
          default: state_q <= S_IDLE;
        endcase
      end
    end
  end

  assign mem_req    = (state_q == S_PTR) || (state_q == S_OPND);
  assign mem_kind   = (state_q == S_OPND) ? cls_kind : 2'(K_READ);
  assign mem_addr   = addr_q;
  assign done       = done_q;
  assign done_addr  = daddr_q;
  assign done_data  = ddata_q;
  assign done_pf    = dpf_q;
  assign fetch_go   = fetch_q;
  assign fetch_addr = pc_q + ADDR_W'(1);
  assign trap       = trap_q;
  assign fault      = fault_q;
  assign int_taken  = int_q;
endmodule

// File: rtl/ea_chain_chk.sv
module ea_chain_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        done,
  input logic        trap,
  input logic        fault,
  input logic        int_taken,
  input logic        fetch_go,
  input logic        done_pf,
  input logic        mem_req,
  input logic        mem_ack,
  input logic [1:0]  mem_kind,
  input logic [29:0] mem_addr,
  input logic        page_fail,
  input logic        irq_pending
);
  logic ended;
  assign ended = done | trap | fault | int_taken;

  assert_single_end_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, trap, fault, int_taken}));

  assert_quiet_at_end_R13: assert property (@(posedge clk) disable iff (!rst_n)
    ended |-> !mem_req);

  assert_prefetch_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_go |-> (done && done_pf));

  assert_trap_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> $past(page_fail));

  assert_irq_only_on_ptr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    int_taken |-> ($past(irq_pending) && $past(mem_req) && $past(mem_kind) == 2'd0));

  assert_req_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !page_fail && !irq_pending) |=>
      (mem_req && $stable(mem_addr) && $stable(mem_kind)));
endmodule

bind ea_chain_seq ea_chain_chk u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .trap(trap), .fault(fault),
  .int_taken(int_taken), .fetch_go(fetch_go), .done_pf(done_pf),
  .mem_req(mem_req), .mem_ack(mem_ack), .mem_kind(mem_kind),
  .mem_addr(mem_addr), .page_fail(page_fail), .irq_pending(irq_pending)
);

// File: tb/ea_chain_seq_tb.sv
module ea_chain_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MAXC = 64;
  localparam logic [1:0] OC_DONE = 2'd0, OC_TRAP = 2'd1, OC_FAULT = 2'd2, OC_INT = 2'd3;
  localparam logic [35:0] ACV = 36'hABCDEF012;
  localparam logic [29:0] PCV = 30'h100;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [35:0] insn = '0, ac_data = ACV, idx_data, mem_rdata = '0;
  logic [2:0]  acc_class = '0;
  logic [29:0] pc = PCV;
  logic [3:0]  idx_sel;
  logic        mem_req, mem_ack = 1'b0, page_fail = 1'b0, irq_pending = 1'b0;
  logic [1:0]  mem_kind;
  logic [29:0] mem_addr, done_addr, fetch_addr;
  logic [35:0] done_data;
  logic        done, done_pf, fetch_go, trap, fault, int_taken;

  logic [35:0] xr [16];
  logic [35:0] memv [16];
  logic        hold = 1'b0;
  int          lat_cnt = 0, ack_cnt = 0;
  logic [1:0]  last_kind = '0;
  int          n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign idx_data = xr[idx_sel];

  ea_chain_seq #(.MAX_CHAIN(MAXC)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .insn(insn), .acc_class(acc_class),
    .pc(pc), .ac_data(ac_data), .idx_sel(idx_sel), .idx_data(idx_data),
    .mem_req(mem_req), .mem_kind(mem_kind), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .page_fail(page_fail), .irq_pending(irq_pending),
    .done(done), .done_addr(done_addr), .done_data(done_data), .done_pf(done_pf),
    .fetch_go(fetch_go), .fetch_addr(fetch_addr), .trap(trap), .fault(fault),
    .int_taken(int_taken)
  );

  // Memory responder: two cycles of latency, one-cycle acknowledge.
  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (mem_req && !mem_ack && !hold) begin
      if (lat_cnt == 1) begin
        mem_ack   <= 1'b1;
        mem_rdata <= memv[mem_addr[3:0]];
        ack_cnt   <= ack_cnt + 1;
        last_kind <= mem_kind;
        lat_cnt   <= 0;
      end else lat_cnt <= lat_cnt + 1;
    end else lat_cnt <= 0;
  end

  function automatic logic [35:0] mk(input logic ind, input logic [3:0] idx, input logic [17:0] y);
    return {13'd0, ind, idx, y};
  endfunction

  typedef struct packed {
    logic [31:0] tag;
    logic [35:0] w;
    logic [2:0]  c;
    logic [1:0]  oc;
    logic [29:0] a;
    logic [35:0] d;
    logic        p;
    logic [7:0]  n;
    logic [1:0]  k;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{"R8  ", mk(1'b0, 4'd0, 18'd7), 3'd0, OC_DONE, 30'd7, 36'd0, 1'b0, 8'd0, 2'd0},
    '{"R9  ", mk(1'b0, 4'd1, 18'd9), 3'd1, OC_DONE, 30'd13, 36'd0, 1'b1, 8'd0, 2'd0},
    '{"R2  ", mk(1'b0, 4'd3, 18'd5), 3'd2, OC_DONE, 30'd4, 36'd4, 1'b0, 8'd0, 2'd0},
    '{"R11 ", mk(1'b0, 4'd0, 18'd5), 3'd4, OC_DONE, 30'd5, 36'h123456789, 1'b0, 8'd1, 2'd0},
    '{"R9  ", mk(1'b0, 4'd0, 18'd7), 3'd5, OC_DONE, 30'd7, 36'hF0F0F0F0F, 1'b1, 8'd1, 2'd0},
    '{"R10 ", mk(1'b0, 4'd0, 18'd7), 3'd3, OC_DONE, 30'd7, ACV, 1'b0, 8'd1, 2'd1},
    '{"R3  ", mk(1'b1, 4'd0, 18'd1), 3'd4, OC_DONE, 30'd5, 36'h123456789, 1'b0, 8'd2, 2'd0},
    '{"R3  ", mk(1'b1, 4'd0, 18'd2), 3'd4, OC_DONE, 30'd5, 36'h123456789, 1'b0, 8'd4, 2'd0},
    '{"R11 ", mk(1'b1, 4'd2, 18'd3), 3'd7, OC_DONE, 30'd5, 36'h123456789, 1'b0, 8'd3, 2'd3},
    '{"R2  ", {2'b11, 34'd0} | mk(1'b0, 4'd0, 18'd7), 3'd6, OC_DONE, 30'd7, 36'hF0F0F0F0F, 1'b0, 8'd1, 2'd2},
    '{"R8  ", mk(1'b1, 4'd0, 18'd1), 3'd2, OC_DONE, 30'd5, 36'd5, 1'b0, 8'd1, 2'd0},
    '{"R4  ", mk(1'b1, 4'd0, 18'd3), 3'd4, OC_FAULT, 30'd0, 36'd0, 1'b0, 8'd1, 2'd0},
    '{"R5  ", mk(1'b1, 4'd0, 18'd6), 3'd4, OC_FAULT, 30'd0, 36'd0, 1'b0, 8'(MAXC), 2'd0},
    '{"R2  ", mk(1'b1, 4'd0, 18'd8), 3'd4, OC_DONE, 30'd7, 36'hF0F0F0F0F, 1'b0, 8'd2, 2'd0}
  };

  int          got_oc;
  logic [29:0] got_addr, got_faddr;
  logic [35:0] got_data;
  logic        got_pf, got_fgo, got_req;
  int          ack_base;

  task automatic chk(input logic [31:0] tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic launch(input logic [35:0] w, input logic [2:0] c);
    @(negedge clk);
    insn = w; acc_class = c; start = 1'b1;
    ack_base = ack_cnt;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic await_end();
    int n = 0;
    got_oc = -1;
    while (got_oc < 0 && n < 5000) begin
      @(negedge clk);
      n++;
      if (done || trap || fault || int_taken) begin
        got_oc    = done ? 0 : trap ? 1 : fault ? 2 : 3;
        got_addr  = done_addr;
        got_data  = done_data;
        got_pf    = done_pf;
        got_fgo   = fetch_go;
        got_faddr = fetch_addr;
        got_req   = mem_req;
      end
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R13 watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 16; i++) begin xr[i] = '0; memv[i] = '0; end
    xr[0] = 36'h7;  xr[1] = 36'h4;  xr[2] = 36'h1;  xr[3] = 36'hFFFFFFFFF;
    memv[1] = {2'b00, 4'd0, 30'd5};
    memv[2] = {2'b10, 11'd0, 1'b1, 4'd2, 18'd3};
    memv[3] = {2'b11, 34'd1};
    memv[4] = {2'b01, 4'd0, 30'd1};
    memv[5] = 36'h123456789;
    memv[6] = {2'b01, 4'd0, 30'd6};
    memv[7] = 36'hF0F0F0F0F;
    memv[8] = {2'b00, 4'd1, 30'd3};

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1  ", 64'({done, trap, fault, int_taken, fetch_go, mem_req}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1  ", 64'({done, trap, fault, int_taken, fetch_go, mem_req}), 64'd0);

    for (int i = 0; i < NV; i++) begin
      launch(VECS[i].w, VECS[i].c);
      await_end();
      chk(VECS[i].tag, 64'(got_oc), 64'(VECS[i].oc));
      chk("R13 ", 64'(got_req), 64'd0);
      chk(VECS[i].tag, 64'(ack_cnt - ack_base), 64'(VECS[i].n));
      if (VECS[i].oc == OC_DONE) begin
        chk(VECS[i].tag, 64'(got_addr), 64'(VECS[i].a));
        chk(VECS[i].tag, 64'(got_data), 64'(VECS[i].d));
        chk("R9  ", 64'({got_pf, got_fgo}), 64'({VECS[i].p, VECS[i].p}));
        if (VECS[i].p) chk("R9  ", 64'(got_faddr), 64'(PCV + 30'd1));
        if (VECS[i].c >= 3'd3) chk("R11 ", 64'(last_kind), 64'(VECS[i].k));
      end
      repeat (2) @(negedge clk);
    end

    // R7: page fail while a pointer read is outstanding
    hold = 1'b1;
    launch(mk(1'b1, 4'd0, 18'd1), 3'd4);
    repeat (2) @(negedge clk);
    page_fail = 1'b1;
    await_end();
    page_fail = 1'b0;
    chk("R7  ", 64'(got_oc), 64'(OC_TRAP));
    chk("R7  ", 64'(got_req), 64'd0);

    // R7: page fail during a write test
    launch(mk(1'b0, 4'd0, 18'd7), 3'd3);
    repeat (2) @(negedge clk);
    page_fail = 1'b1;
    await_end();
    page_fail = 1'b0;
    chk("R7  ", 64'(got_oc), 64'(OC_TRAP));

    // R6: interrupt while waiting for a pointer word
    launch(mk(1'b1, 4'd0, 18'd1), 3'd4);
    repeat (2) @(negedge clk);
    irq_pending = 1'b1;
    await_end();
    irq_pending = 1'b0;
    chk("R6  ", 64'(got_oc), 64'(OC_INT));
    chk("R6  ", 64'(got_req), 64'd0);
    chk("R6  ", 64'(ack_cnt - ack_base), 64'd0);
    hold = 1'b0;
    repeat (2) @(negedge clk);

    // R6: interrupt during an operand read has no effect
    irq_pending = 1'b1;
    launch(mk(1'b0, 4'd0, 18'd5), 3'd4);
    await_end();
    irq_pending = 1'b0;
    chk("R6  ", 64'(got_oc), 64'(OC_DONE));
    chk("R6  ", 64'(got_data), 64'h123456789);
    repeat (2) @(negedge clk);

    // R12: a second start while busy is ignored
    hold = 1'b1;
    launch(mk(1'b0, 4'd0, 18'd5), 3'd4);
    repeat (2) @(negedge clk);
    launch(mk(1'b0, 4'd0, 18'd7), 3'd0);
    hold = 1'b0;
    await_end();
    chk("R12 ", 64'(got_oc), 64'(OC_DONE));
    chk("R12 ", 64'(got_addr), 64'd5);
    chk("R12 ", 64'(got_data), 64'h123456789);
    begin
      int extra = 0;
      for (int j = 0; j < 6; j++) begin
        @(negedge clk);
        if (done || mem_req) extra++;
      end
      chk("R12 ", 64'(extra), 64'd0);
    end

    finish_run();
  end
endmodule